// File: doc/BRIEF.md
# Fuse Word Auto-Read Sequencer

This block fetches one 32-bit word from a one-time-programmable fuse array without software toggling the array's control pins. Software selects the automatic mode and then writes a word address with the enable and read bits into the auto-control register. The block then runs a cycle counter from zero. It drives chip-select, program-enable, load, address-valid and strobe toward the fuse array, and each of these pins is active only inside its own programmable cycle window. The array output is captured into the data register on the cycle the strobe window closes. When the sequence ends, a sticky completion flag is raised. Software clears the flag by writing a one to it.

Each window register holds a start cycle in its upper half and an end cycle in its lower half. A pin is active on the counter values from start up to end, excluding end. A register holding zero keeps its pin idle for the whole sequence. The sequence lasts until the counter reaches the largest end value over all five windows. Outside a sequence the array is held in standby.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After reset the mode register reads 0 (automatic mode) and the status and auto-control registers read 0. The window registers at 0x3C, 0x40, 0x44, 0x48 and 0x4C (chip-select, program-enable, load, address-valid, strobe) read 0x0000000B, 0x0000000B, 0x0000000B, 0x0002000A and 0x00050008. In standby `fz_csn`=1, `fz_pgmn`=1 and load, address-valid and strobe are 0.
- R2: A write to 0x24 with bit 0 (enable) and bit 1 (read) both set starts a sequence when the block is idle and in automatic mode. The counter value is 0 in the first cycle after that write and rises by one per cycle. Each pin is active exactly when the counter is at least the start field (bits 31:16) and below the end field (bits 15:0) of its window register.
- R3: Chip-select (`fz_csn`) and program-enable (`fz_pgmn`) are active low. Load, address-valid and strobe are active high. `fz_addr` carries bits 25:16 of the accepted auto-control write.
- R4: At the counter value equal to the strobe end field, the data register (0x20) loads `fz_rdata`.
- R5: With M the largest end field, the sequence ends at counter value M. From the next cycle, status bit 0 (0x18) and `irq` are 1, and bits 1:0 of 0x24 read 0.
- R6: Writing 1 to status bit 0 clears it. Writing 0 leaves it set.
- R7: A write to 0x24 during a sequence is ignored. The running address and the captured data are those of the first request.
- R8: While mode bit 0 (0x00) is 1 (user mode), writes to 0x24 start no sequence and the pins stay in standby.
- R9: A window register holding 0 keeps its pin inactive for the whole sequence. If all windows are 0, the sequence ends after one cycle.
- R10: A write to 0x24 without both the enable and read bits set starts no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset for writes and reads |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| irq | output | 1 | Completion flag (status bit 0) |
| fz_csn | output | 1 | Fuse chip-select, active low |
| fz_pgmn | output | 1 | Fuse program-enable, active low |
| fz_load | output | 1 | Fuse load, active high |
| fz_addr_vld | output | 1 | Fuse address valid, active high |
| fz_strobe | output | 1 | Fuse read strobe, active high |
| fz_addr | output | 10 | Fuse word address |
| fz_rdata | input | 32 | Fuse array read data |

## Verification
The clock edge that accepts a start write moves the counter to 0, so after k further edges every pin must show its window decode for counter value k. The bench therefore samples the pins at each falling edge, from the one right after the start write up to counter value M, and checks them against windows it computes itself. The completion flag appears one edge after counter value M, which is M+1 edges after the start write; the bench checks that the flag is still low at counter value M and high one falling edge later. The captured word and the cleared auto-control bits are read only after that point. For the ignored-write, user-mode and incomplete-request cases, the bench watches the pins and the flag for a fixed number of cycles longer than any sequence.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int NPIN = 5;
  localparam int PIN_CS   = 0;
  localparam int PIN_PGM  = 1;
  localparam int PIN_LOAD = 2;
  localparam int PIN_ADDR = 3;
  localparam int PIN_STRB = 4;

  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h18;
  localparam logic [7:0] OFS_DATA = 8'h20;
  localparam logic [7:0] OFS_ACTL = 8'h24;
  localparam logic [7:0] OFS_WIN0 = 8'h3C;

  typedef struct packed {
    logic [15:0] on;
    logic [15:0] off;
  } win_t;

  function automatic win_t win_reset(input int idx);
    win_t w;
    case (idx)
      PIN_ADDR: begin w.on = 16'd2; w.off = 16'd10; end
      PIN_STRB: begin w.on = 16'd5; w.off = 16'd8;  end
      default:  begin w.on = 16'd0; w.off = 16'd11; end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/fz_regs.sv
module fz_regs
  import fz_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int ADDR_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic                  seq_busy,
  input  logic                  seq_done,
  input  logic                  cap_en,
  input  logic [DW-1:0]         cap_data,
  output logic                  mode_user,
  output logic                  start,
  output logic                  irq,
  output logic [ADDR_W-1:0]     word_addr,
  output win_t [NPIN-1:0]       win
);
  localparam int ADDR_LSB = 16;

  logic          actl_en, actl_rd;
  logic          stat_q;
  logic [DW-1:0] data_q;
  logic          wr_mode, wr_stat, wr_actl;

  assign wr_mode = bus_wr && (bus_addr == AW'(OFS_MODE));
  assign wr_stat = bus_wr && (bus_addr == AW'(OFS_STAT));
  assign wr_actl = bus_wr && (bus_addr == AW'(OFS_ACTL));
  assign start   = wr_actl && !seq_busy && !mode_user && bus_wdata[0] && bus_wdata[1];
  assign irq     = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_user <= 1'b0;
      stat_q    <= 1'b0;
      data_q    <= '0;
      actl_en   <= 1'b0;
      actl_rd   <= 1'b0;
      word_addr <= '0;
    end else begin
      if (wr_mode) mode_user <= bus_wdata[0];
      if (seq_done)                    stat_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) stat_q <= 1'b0;
      if (cap_en) data_q <= cap_data;
      if (seq_done) begin
        actl_en <= 1'b0;
        actl_rd <= 1'b0;
      end else if (wr_actl && !seq_busy) begin
        actl_en   <= bus_wdata[0];
        actl_rd   <= bus_wdata[1];
        word_addr <= bus_wdata[ADDR_LSB +: ADDR_W];
      end
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_win
    localparam logic [AW-1:0] OFS = AW'(OFS_WIN0 + 8'(4 * i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          win[i] <= win_reset(i);
      else if (bus_wr && bus_addr == OFS) win[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_MODE): bus_rdata = DW'(mode_user);
      AW'(OFS_STAT): bus_rdata = DW'(stat_q);
      AW'(OFS_DATA): bus_rdata = data_q;
      AW'(OFS_ACTL): begin
        bus_rdata[0] = actl_en;
        bus_rdata[1] = actl_rd;
        bus_rdata[ADDR_LSB +: ADDR_W] = word_addr;
      end
      default: begin
        for (int i = 0; i < NPIN; i++)
          if (bus_addr == AW'(OFS_WIN0 + 8'(4 * i))) bus_rdata = win[i];
      end
    endcase
  end
endmodule

// File: rtl/fz_seq.sv
module fz_seq
  import fz_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  win_t [NPIN-1:0]  win,
  output logic             busy,
  output logic [CW-1:0]    cnt,
  output logic             done,
  output logic             cap_en
);
  logic [CW-1:0] last_cyc;

  always_comb begin
    last_cyc = '0;
    for (int i = 0; i < NPIN; i++)
      if (CW'(win[i].off) > last_cyc) last_cyc = CW'(win[i].off);
  end

  assign done   = busy && (cnt == last_cyc);
  assign cap_en = busy && (cnt == CW'(win[PIN_STRB].off));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fz_pin_win.sv
module fz_pin_win #(
  parameter int CW = 16
) (
  input  logic          busy,
  input  logic [CW-1:0] cnt,
  input  logic [15:0]   on,
  input  logic [15:0]   off,
  output logic          act
);
  logic armed;
  assign armed = (on != '0) || (off != '0);
  assign act   = busy && armed && (cnt >= CW'(on)) && (cnt < CW'(off));
endmodule

// File: rtl/fuse_autoread_ctrl.sv
module fuse_autoread_ctrl
  import fz_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int ADDR_W = 10,
  parameter int CW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              fz_csn,
  output logic              fz_pgmn,
  output logic              fz_load,
  output logic              fz_addr_vld,
  output logic              fz_strobe,
  output logic [ADDR_W-1:0] fz_addr,
  input  logic [DW-1:0]     fz_rdata
);
  win_t [NPIN-1:0] win;
  logic            seq_busy, seq_done, cap_en, start, mode_user;
  logic [CW-1:0]   cnt;
  logic [ADDR_W-1:0] word_addr;
  logic [NPIN-1:0] act;

  fz_regs #(.AW(AW), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_busy(seq_busy),
    .seq_done(seq_done), .cap_en(cap_en), .cap_data(fz_rdata),
    .mode_user(mode_user), .start(start), .irq(irq),
    .word_addr(word_addr), .win(win)
  );

  fz_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .win(win),
    .busy(seq_busy), .cnt(cnt), .done(seq_done), .cap_en(cap_en)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    fz_pin_win #(.CW(CW)) u_win (
      .busy(seq_busy), .cnt(cnt), .on(win[i].on), .off(win[i].off), .act(act[i])
    );
  end

  assign fz_csn      = ~act[PIN_CS];
  assign fz_pgmn     = ~act[PIN_PGM];
  assign fz_load     = act[PIN_LOAD];
  assign fz_addr_vld = act[PIN_ADDR];
  assign fz_strobe   = act[PIN_STRB];
  assign fz_addr     = word_addr;
endmodule

// File: rtl/fz_autoread_chk.sv
module fz_autoread_chk
  import fz_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              irq,
  input logic              fz_csn,
  input logic              fz_pgmn,
  input logic              fz_load,
  input logic              fz_addr_vld,
  input logic              fz_strobe,
  input logic              seq_busy,
  input logic              seq_done,
  input logic              mode_user,
  input logic [ADDR_W-1:0] word_addr
);
  // R1
  standby_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (fz_csn && fz_pgmn && !fz_load && !fz_strobe && !fz_addr_vld));

  // R5
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (irq && !seq_busy));

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_STAT) && bus_wdata[0] && !seq_done) |=> !irq);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !seq_done && bus_wr && bus_addr == AW'(OFS_ACTL)) |=> $stable(word_addr));

  // R8
  user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_user && !seq_busy) |=> !seq_busy);
endmodule

bind fuse_autoread_ctrl fz_autoread_chk #(.AW(AW), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .fz_csn(fz_csn), .fz_pgmn(fz_pgmn),
  .fz_load(fz_load), .fz_addr_vld(fz_addr_vld), .fz_strobe(fz_strobe),
  .seq_busy(seq_busy), .seq_done(seq_done), .mode_user(mode_user),
  .word_addr(word_addr)
);

// File: tb/fuse_autoread_ctrl_tb.sv
module fuse_autoread_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, fz_csn, fz_pgmn, fz_load, fz_addr_vld, fz_strobe;
  logic [9:0]  fz_addr;
  logic [31:0] mdl_q = '0;

  int checks = 0;
  int errors = 0;
  int ws[5];
  int we[5];
  logic [31:0] exp_data = '0;

  always #2 clk = ~clk;

  fuse_autoread_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .fz_csn(fz_csn), .fz_pgmn(fz_pgmn), .fz_load(fz_load),
    .fz_addr_vld(fz_addr_vld), .fz_strobe(fz_strobe), .fz_addr(fz_addr),
    .fz_rdata(mdl_q)
  );

  function automatic logic [31:0] fmix(input logic [9:0] a);
    return (32'(a) * 32'h0100_0193) ^ 32'hC0DE_5EED;
  endfunction

  // behavioural fuse array: latches the word while strobed and selected
  always @(posedge clk) if (fz_strobe && !fz_csn) mdl_q <= fmix(fz_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_win(input int i, input int on, input int off);
    wr(8'h3C + 8'(4 * i), {16'(on), 16'(off)});
    ws[i] = on; we[i] = off;
  endtask

  function automatic bit win_act(input int i, input int k);
    return (ws[i] != 0 || we[i] != 0) && k >= ws[i] && k < we[i];
  endfunction

  task automatic run_seq(input logic [9:0] a);
    int m = 0;
    bit hit = 0;
    logic [31:0] v;
    logic [4:0] exp_p;
    for (int i = 0; i < 5; i++) if (we[i] > m) m = we[i];
    for (int k = 0; k <= m; k++)
      if (win_act(0, k) && win_act(4, k)) hit = 1;
    wr(8'h24, {6'd0, a, 14'd0, 2'b11});
    for (int k = 0; k <= m; k++) begin
      @(negedge clk);
      exp_p = {win_act(4, k), win_act(3, k), win_act(2, k), !win_act(1, k), !win_act(0, k)};
      // R2 R3 R9 window decode and pin polarity
      check("R2", {27'd0, fz_strobe, fz_addr_vld, fz_load, fz_pgmn, fz_csn}, {27'd0, exp_p});
      if (win_act(3, k)) check("R3", {22'd0, fz_addr}, {22'd0, a});
      check("R5", {31'd0, irq}, 32'd0);
    end
    @(negedge clk);
    check("R5", {31'd0, irq}, 32'd1);
    if (hit) exp_data = fmix(a);
    rd(8'h24, v);
    check("R5", {30'd0, v[1:0]}, 32'd0);
    rd(8'h20, v);
    check("R4", v, exp_data);
    wr(8'h18, 32'd0);
    @(negedge clk);
    check("R6", {31'd0, irq}, 32'd1);
    wr(8'h18, 32'd1);
    @(negedge clk);
    check("R6", {31'd0, irq}, 32'd0);
  endtask

  task automatic idle_watch(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(req, {27'd0, fz_strobe, fz_addr_vld, fz_load, fz_pgmn, fz_csn}, 32'h3);
      check(req, {31'd0, irq}, 32'd0);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    ws = '{0, 0, 0, 2, 5};
    we = '{11, 11, 11, 10, 8};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", {27'd0, fz_strobe, fz_addr_vld, fz_load, fz_pgmn, fz_csn}, 32'h3);
    check("R1", {31'd0, irq}, 32'd0);
    rd(8'h00, v); check("R1", v, 32'd0);
    rd(8'h18, v); check("R1", v, 32'd0);
    rd(8'h24, v); check("R1", v, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(8'h3C + 8'(4 * i), v);
      check("R1", v, {16'(ws[i]), 16'(we[i])});
    end

    // R2 R4 R5 sweep of word addresses with reset windows
    for (int a = 0; a < 40; a++) run_seq(10'(a * 27 + 3));
    run_seq(10'h000);
    run_seq(10'h3FF);
    run_seq(10'h200);

    // R2 custom windows, R9 program-enable window zero
    set_win(0, 1, 20); set_win(1, 0, 0); set_win(2, 2, 19);
    set_win(3, 3, 18); set_win(4, 6, 9);
    run_seq(10'h155);
    run_seq(10'h2AA);

    // R9 strobe zero: data must keep the previous word
    set_win(4, 0, 0); set_win(0, 0, 4); set_win(2, 0, 0); set_win(3, 0, 0);
    run_seq(10'h0F0);

    // R9 all windows zero: done after one cycle
    set_win(0, 0, 0);
    run_seq(10'h0F1);

    // back to reset windows
    set_win(0, 0, 11); set_win(1, 0, 11); set_win(2, 0, 11);
    set_win(3, 2, 10); set_win(4, 5, 8);

    // R7 write during a sequence is ignored
    wr(8'h24, {6'd0, 10'h123, 14'd0, 2'b11});
    wr(8'h24, {6'd0, 10'h321, 14'd0, 2'b11});
    repeat (20) @(negedge clk);
    check("R7", {31'd0, irq}, 32'd1);
    rd(8'h20, v); check("R7", v, fmix(10'h123));
    rd(8'h24, v); check("R7", {22'd0, v[25:16]}, 32'h123);
    wr(8'h18, 32'd1);

    // R8 user mode blocks a start
    wr(8'h00, 32'd1);
    wr(8'h24, {6'd0, 10'h0AA, 14'd0, 2'b11});
    idle_watch("R8", 20);
    rd(8'h00, v); check("R8", v, 32'd1);
    wr(8'h00, 32'd0);

    // R10 incomplete requests do not start
    wr(8'h24, {6'd0, 10'h0BB, 14'd0, 2'b01});
    idle_watch("R10", 16);
    wr(8'h24, {6'd0, 10'h0BB, 14'd0, 2'b10});
    idle_watch("R10", 16);
    rd(8'h20, v); check("R10", v, fmix(10'h123));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule